// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral master for a single slave. A host reaches it through a small register window of five 32-bit locations. These hold the chip-select control, the interface setup, the outgoing word, the incoming word and a completion cause. Writing the outgoing word starts one full-duplex exchange. The serial clock idles low, the master changes its output data on falling edges, and the incoming line is sampled on rising edges. Words are 8 or 16 bits, chosen by a setup bit, and the length can change between words.

The serial clock is derived from the system clock by an even divider. A 5-bit prescale code in the setup register carries half the divide ratio in its low nibble, which gives ratios of 4 to 30. Chip select is under direct software control and is never moved by the shifter. When a word has been exchanged, the cause register reads nonzero and the received word is available. Software writes the cause register to clear it before it launches the next word.

The host port is a plain register bus. Every access completes in the cycle it is presented. Read data is combinational on the address, and there is no back-pressure. There is no streaming interface: one word is in flight at most, and its completion is reported through the cause register.

Top module: `spi_regfile_master`

## Requirements
- R1: After reset, chip select is released (`spi_cs_n` = 1), `spi_sck` is low, the cause register reads 0, the control register reads 0, and the setup register reads 0x12 (8-bit words, divide ratio 4).
- R2: Bit 0 of the control register at offset 0x00 drives chip select. A value of 1 asserts it (`spi_cs_n` = 0) and 0 releases it, one cycle after the write. The bit reads back as written.
- R3: A write to the transmit register at offset 0x08 while idle starts one exchange. Bits are sent most significant first. `spi_sck` is low whenever no exchange is running. `spi_mosi` stays constant while `spi_sck` is high. `spi_miso` is captured on rising `spi_sck` edges.
- R4: When bit 5 of the setup register at offset 0x04 is 0, an exchange is 8 clock pulses long. Only bits [7:0] of the written word are sent, and the received word reads back zero-extended to 32 bits.
- R5: When setup bit 5 is 1, an exchange is 16 clock pulses long, and bits [15:0] are sent and received.
- R6: Setup bits [3:0] give the `spi_sck` half period in system clocks, so the divide ratio is twice that nibble. A nibble of 0 or 1 acts as 2. Bit 4 is the marker bit of the 5-bit prescale code and does not change the ratio.
- R7: When an exchange completes, the cause register at offset 0x10 reads 1 and the receive register at offset 0x0C holds the word captured from `spi_miso`.
- R8: A write of any value to the cause register clears it to 0. The next completion sets it to 1 again.
- R9: A write to the transmit register while an exchange is running is ignored. The running word is finished unchanged and no further exchange follows.
- R10: Control bit 1 reads 1 while an exchange is running and 0 otherwise. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default parameters: a 16-bit maximum word, an 8-bit narrow word and a 4-bit half-period nibble. With these values both word lengths can be reached, as can the whole range of prescale codes, from the clamped nibbles below 2 up to the slowest ratio of 30. A modelled slave shifts a known word back on `spi_miso`. A scoreboard compares every word seen on `spi_mosi`, and the spacing between rising clock edges, against what the driver queued. Transmit writes issued in the middle of an exchange, and cause writes with nonzero data, are used to exercise the ignore and clear rules.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned REG_ADDR_W = 5;
  localparam int unsigned REG_DATA_W = 32;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_SETUP = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_TXD   = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_RXD   = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_CAUSE = 5'h10;
  localparam logic [5:0] SETUP_RESET = 6'h12;
endpackage

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
  parameter int unsigned HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  localparam logic [HALF_W-1:0] HALF_MIN = HALF_W'(2);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_eff;

  assign half_eff = (half < HALF_MIN) ? HALF_MIN : half;
  assign tick     = run && (cnt_q == half_eff - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + HALF_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned NARROW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output logic                sck,
  output logic                mosi,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                done
);
  localparam int unsigned CNT_W = $clog2(WORD_MAX + 1);
  localparam int unsigned PAD_W = WORD_MAX - NARROW;

  logic [WORD_MAX-1:0] txs_q, rxs_q;
  logic [CNT_W-1:0]    left_q;
  logic                wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      done   <= 1'b0;
      wide_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      left_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          sck    <= 1'b0;
          wide_q <= wide;
          rxs_q  <= '0;
          txs_q  <= wide ? tx_word : {tx_word[NARROW-1:0], {PAD_W{1'b0}}};
          left_q <= wide ? CNT_W'(WORD_MAX) : CNT_W'(NARROW);
        end
      end else if (tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          rxs_q <= {rxs_q[WORD_MAX-2:0], miso};
        end else begin
          sck    <= 1'b0;
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            txs_q <= {txs_q[WORD_MAX-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi    = busy & txs_q[WORD_MAX-1];
  assign rx_word = wide_q ? rxs_q : {{PAD_W{1'b0}}, rxs_q[NARROW-1:0]};

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R3
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !sck); // R7
endmodule

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned HALF_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  input  logic                  busy,
  input  logic                  done,
  input  logic [WORD_MAX-1:0]   rx_word,
  output logic                  start,
  output logic                  wide,
  output logic [HALF_W-1:0]     half,
  output logic [WORD_MAX-1:0]   tx_word,
  output logic                  cs_n
);
  logic                cs_q, cause_q;
  logic [5:0]          setup_q;
  logic [WORD_MAX-1:0] txd_q, rxd_q;
  logic                wr;

  assign wr      = reg_en && reg_we;
  assign start   = wr && (reg_addr == OFS_TXD) && !busy;
  assign wide    = setup_q[5];
  assign half    = setup_q[HALF_W-1:0];
  assign tx_word = reg_wdata[WORD_MAX-1:0];
  assign cs_n    = !cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      cause_q <= 1'b0;
      setup_q <= SETUP_RESET;
      txd_q   <= '0;
      rxd_q   <= '0;
    end else begin
      if (wr && reg_addr == OFS_CTRL)  cs_q    <= reg_wdata[0];
      if (wr && reg_addr == OFS_SETUP) setup_q <= reg_wdata[5:0];
      if (start)                       txd_q   <= tx_word;
      if (done) begin
        cause_q <= 1'b1;
        rxd_q   <= rx_word;
      end else if (wr && reg_addr == OFS_CAUSE) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:  reg_rdata[1:0] = {busy, cs_q};
      OFS_SETUP: reg_rdata[5:0] = setup_q;
      OFS_TXD:   reg_rdata[WORD_MAX-1:0] = txd_q;
      OFS_RXD:   reg_rdata[WORD_MAX-1:0] = rxd_q;
      OFS_CAUSE: reg_rdata[0] = cause_q;
      default:   reg_rdata = '0;
    endcase
  end

  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == OFS_CTRL) |=> (cs_n == !$past(reg_wdata[0]))); // R2
  AST_CAUSE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause_q); // R7
  AST_CAUSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == OFS_CAUSE && !done) |=> !cause_q); // R8
  AST_TX_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && reg_addr == OFS_TXD) |=> $stable(txd_q)); // R9
endmodule

// File: rtl/spi_regfile_master.sv
module spi_regfile_master
  import spi_rm_pkg::*;
#(
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned NARROW   = 8,
  parameter int unsigned HALF_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic                  spi_sck,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic                  spi_cs_n
);
  logic                busy, done, start, wide, tick;
  logic [HALF_W-1:0]   half;
  logic [WORD_MAX-1:0] tx_word, rx_word;

  spi_rm_regs #(.WORD_MAX(WORD_MAX), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .rx_word(rx_word), .start(start),
    .wide(wide), .half(half), .tx_word(tx_word), .cs_n(spi_cs_n));

  spi_rm_clkdiv #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick));

  spi_rm_shifter #(.WORD_MAX(WORD_MAX), .NARROW(NARROW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .tx_word(tx_word), .tick(tick), .miso(spi_miso), .busy(busy),
    .sck(spi_sck), .mosi(spi_mosi), .rx_word(rx_word), .done(done));
endmodule

// File: tb/tb_spi_regfile_master.sv
module tb_spi_regfile_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [15:0] slv_sh = '0;
  assign spi_miso = slv_sh[15];

  int          exp_w[$];
  logic [15:0] exp_mosi[$];
  int          exp_half = 2;
  logic [15:0] mon_sh = '0;
  int          mon_cnt = 0;
  int          last_rise = 0;

  spi_regfile_master dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave: shifts its word out, changing on falling sck
  always @(negedge spi_sck) slv_sh <= {slv_sh[14:0], 1'b0};

  // monitor: collects mosi on rising sck, compares against queue
  always @(posedge spi_sck) begin
    if (mon_cnt > 0) check("R6 sck period", cyc - last_rise, 2 * exp_half);
    last_rise = cyc;
    mon_sh = {mon_sh[14:0], spi_mosi};
    mon_cnt++;
    if (exp_w.size() == 0) begin
      check("R9 unexpected sck pulse", 1, 0);
      mon_cnt = 0;
    end else if (mon_cnt == exp_w[0]) begin
      check("R3 mosi word", mon_sh & ((exp_w[0] == 16) ? 16'hFFFF : 16'h00FF),
            exp_mosi[0]);
      void'(exp_w.pop_front());
      void'(exp_mosi.pop_front());
      mon_cnt = 0;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cause();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(5'h10, v);
      if (v != 0) return;
    end
    check("R7 cause timeout", 0, 1);
  endtask

  // driver: queue expectations, run one word, check cause and rx
  task automatic xfer(bit wide, logic [5:0] code, logic [31:0] tx,
                      logic [15:0] slv, string req);
    logic [31:0] v;
    int h;
    h = (code[3:0] < 2) ? 2 : int'(code[3:0]);
    wr(5'h04, {26'd0, wide, code[4:0]});
    wr(5'h10, 32'h0);
    exp_half = h;
    exp_w.push_back(wide ? 16 : 8);
    exp_mosi.push_back(wide ? tx[15:0] : {8'h00, tx[7:0]});
    slv_sh = wide ? slv : {slv[7:0], 8'h00};
    wr(5'h08, tx);
    wait_cause();
    rd(5'h0C, v);
    check({req, " R7 rx word"}, v, wide ? {16'h0, slv} : {24'h0, slv[7:0]});
    rd(5'h10, v);
    check("R7 cause set", v, 32'h1);
    rd(5'h00, v);
    check("R10 busy clear after done", v[1], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h04, v); check("R1 setup reset", v, 32'h12);
    rd(5'h10, v); check("R1 cause reset", v, 32'h0);
    rd(5'h00, v); check("R1 ctrl reset", v, 32'h0);
    check("R1 cs released", spi_cs_n, 1'b1);
    check("R1 sck low", spi_sck, 1'b0);
    // R2 chip select
    wr(5'h00, 32'h1);
    check("R2 cs asserted", spi_cs_n, 1'b0);
    // R10 busy bit is read-only
    wr(5'h00, 32'h3);
    rd(5'h00, v); check("R10 busy not writable", v, 32'h1);
    // R4 narrow word, ratio 4
    xfer(0, 6'h12, 32'h0000_00A5, 16'h003C, "R4 narrow");
    // R5 wide word, ratio 10
    xfer(1, 6'h15, 32'h0000_BEEF, 16'h1234, "R5 wide");
    // R4 upper bits dropped, ratio 30
    xfer(0, 6'h1F, 32'hFFFF_12C3, 16'h0081, "R4 upper dropped");
    // R6 nibble below 2 clamps to ratio 4
    xfer(1, 6'h00, 32'h0000_8001, 16'hF00F, "R6 clamp");
    xfer(0, 6'h11, 32'h0000_0055, 16'h00AA, "R6 clamp one");
    // R8 any value clears cause
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); check("R8 cause cleared", v, 32'h0);
    // R9 write during transfer ignored, R10 busy visible
    wr(5'h04, 32'h14);
    exp_half = 4;
    exp_w.push_back(8);
    exp_mosi.push_back(16'h0096);
    slv_sh = 16'h6900;
    wr(5'h08, 32'h96);
    repeat (10) @(negedge clk);
    rd(5'h00, v); check("R10 busy set", v[1], 1'b1);
    wr(5'h08, 32'h3C);
    rd(5'h08, v); check("R9 tx reg unchanged", v, 32'h96);
    wait_cause();
    rd(5'h0C, v); check("R9 rx word", v, 32'h69);
    repeat (200) @(negedge clk);
    check("R9 no extra transfer", exp_w.size(), 0);
    rd(5'h00, v); check("R9 idle after", v[1], 1'b0);
    // R8 completion sets cause again after clear
    wr(5'h10, 32'h0);
    xfer(1, 6'h13, 32'h0000_0F0F, 16'hA5A5, "R8 reset again");
    // R2 release
    wr(5'h00, 32'h0);
    check("R2 cs released", spi_cs_n, 1'b1);
    check("R3 sck idle low", spi_sck, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule